// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that a synchronous DRAM controller issues for that burst. A request gives the starting column, a three-bit length code and an ordering choice. From the cycle after the request the block puts out one column per clock, with a valid flag. It raises a last flag on the final beat of a fixed-length burst. Sequential bursts count upward and wrap inside the aligned block that the burst length defines. Interleaved bursts XOR the start offset with a beat counter. A full-page burst walks the whole row and keeps going until it is stopped.

A stop strobe ends the running burst. A new request may arrive on any cycle and replaces the burst in progress at once. No alignment to even cycles is needed. A full-page length asked for together with interleaved ordering is not a legal combination. Such a request raises an illegal flag for that burst and runs as an eight-beat interleaved burst.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held and just after it is released, `beatValid`, `beatLast` and `lenIllegal` are low.
- R2: A `burstStart` sampled at a rising edge makes `beatValid` high after that edge, with `colOut` equal to the sampled `startCol`.
- R3: Length codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. For sequential ordering (`burstIlv` = 0), the low log2(BL) bits of beat k equal (start + k) mod BL, and the upper bits keep the start column's value.
- R4: For interleaved ordering (`burstIlv` = 1), the low log2(BL) bits of beat k equal the start's low bits XOR k, and the upper bits keep the start column's value.
- R5: A length code with bit 2 set and sequential ordering selects full page: beat k is (start + k) mod 2^COL_W, and the burst continues past 2^COL_W beats until it is stopped.
- R6: `beatLast` is high on beat BL-1 of a fixed-length burst and low on its other beats. `beatValid` is low in the cycle after the last beat unless a new start was sampled.
- R7: `beatLast` never rises during a full-page burst.
- R8: A `burstStop` sampled while no start is present makes `beatValid` low after that edge. When start and stop are sampled together, the start wins.
- R9: A start sampled in the middle of a burst begins the new sequence on the very next beat.
- R10: A length code with bit 2 set together with interleaved ordering holds `lenIllegal` high for that burst. The burst runs as an eight-beat interleaved burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| burstStart | input | 1 | Starts a new burst and replaces any burst in progress |
| burstStop | input | 1 | Ends the burst in progress |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | 0/1/2/3 give 1/2/4/8 beats; bit 2 set gives full page |
| burstIlv | input | 1 | 0 for sequential ordering, 1 for interleaved |
| colOut | output | COL_W | Column of the current beat |
| beatValid | output | 1 | `colOut` holds a beat |
| beatLast | output | 1 | Current beat is the final one of a fixed-length burst |
| lenIllegal | output | 1 | The current burst asked for interleaved full page |

## Verification
Every result is due one rising edge after the input that causes it. Start, stop and restart are sampled at an edge, and their effect is visible in the half-cycle that follows. Each later beat moves forward by exactly one edge. The bench drives inputs on the falling edge and compares the outputs at the next falling edge. It compares one beat per falling edge against a model of the sequence built from the requirements. After the final beat of a burst, it checks at one more falling edge that `beatValid` has dropped.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  // Strobes passed from the burst control to the address datapath
  typedef struct packed {
    logic load;   // capture a new start column and ordering
    logic adv;    // step the beat counter
  } colgen_strobe_t;
endpackage

// File: rtl/colgen_dp.sv
module colgen_dp
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  colgen_strobe_t       strb,
  input  logic [COL_W-1:0]     startCol,
  input  logic [2:0]           lenCode,
  input  logic                 burstIlv,
  output logic [COL_W-1:0]     colOut,
  output logic                 atEnd
);
  localparam int FIX_W = 3;  // widest fixed burst is 2**FIX_W beats

  logic [COL_W-1:0] baseQ, cntQ, maskQ, maskNext;
  logic             ilvQ;

  // Mask of the address bits that move within one burst
  always_comb begin
    maskNext = '0;
    if (lenCode[2]) begin
      if (burstIlv) maskNext[FIX_W-1:0] = '1;
      else          maskNext = '1;
    end else begin
      for (int b = 0; b < FIX_W; b++)
        if (b < int'(lenCode[1:0])) maskNext[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
    end else if (strb.load) begin
      baseQ <= startCol;
      cntQ  <= '0;
      maskQ <= maskNext;
      ilvQ  <= burstIlv;
    end else if (strb.adv) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  always_comb begin
    if (ilvQ) colOut = baseQ ^ cntQ;
    else      colOut = (baseQ & ~maskQ) | ((baseQ + cntQ) & maskQ);
  end

  assign atEnd = (cntQ == maskQ);

  // R2: the first beat after a load is the captured start column
  assert_first_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> colOut == $past(startCol));

  // R3: sequential stepping leaves the bits above the burst block alone
  assert_seq_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !ilvQ) |=> ((colOut & ~maskQ) == $past(colOut & ~maskQ)));

  // R4: interleaved columns differ from the start only inside the block
  assert_ilv_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && ilvQ) |=> (((colOut ^ baseQ) & ~maskQ) == '0));
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           burstStart,
  input  logic           burstStop,
  input  logic [2:0]     lenCode,
  input  logic           burstIlv,
  input  logic           atEnd,
  output colgen_strobe_t strb,
  output logic           beatValid,
  output logic           beatLast,
  output logic           lenIllegal
);
  logic activeQ, fullQ, illegalQ;

  assign beatValid  = activeQ;
  assign beatLast   = activeQ && !fullQ && atEnd;
  assign lenIllegal = activeQ && illegalQ;

  always_comb begin
    strb.load = burstStart;
    strb.adv  = activeQ && !burstStart && !burstStop && !beatLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      fullQ    <= 1'b0;
      illegalQ <= 1'b0;
    end else if (burstStart) begin
      activeQ  <= 1'b1;
      fullQ    <= lenCode[2] && !burstIlv;
      illegalQ <= lenCode[2] && burstIlv;
    end else if (burstStop || beatLast) begin
      activeQ  <= 1'b0;
    end
  end

  // R2: a sampled start always yields a beat
  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> beatValid);

  // R6: the burst ends after its last beat unless restarted
  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (beatLast && !burstStart) |=> !beatValid);

  // R7: a full-page burst keeps running while left alone
  assert_full_runs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && fullQ && !burstStop && !burstStart) |=> beatValid);

  // R8: a stop without a start ends the burst
  assert_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (burstStop && !burstStart) |=> !beatValid);

  // R10: interleaved full page is reported
  assert_illegal_R10: assert property (@(posedge clk) disable iff (!rstN)
    (burstStart && lenCode[2] && burstIlv) |=> lenIllegal);
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstStart,
  input  logic             burstStop,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             burstIlv,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             beatLast,
  output logic             lenIllegal
);
  colgen_strobe_t strb;
  logic           atEnd;

  colgen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .burstStart (burstStart),
    .burstStop  (burstStop),
    .lenCode    (lenCode),
    .burstIlv   (burstIlv),
    .atEnd      (atEnd),
    .strb       (strb),
    .beatValid  (beatValid),
    .beatLast   (beatLast),
    .lenIllegal (lenIllegal)
  );

  colgen_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startCol (startCol),
    .lenCode  (lenCode),
    .burstIlv (burstIlv),
    .colOut   (colOut),
    .atEnd    (atEnd)
  );
endmodule

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;
  localparam int COL_W = 9;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             burstStart = 1'b0;
  logic             burstStop = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = '0;
  logic             burstIlv = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             beatValid, beatLast, lenIllegal;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .burstStop(burstStop),
    .startCol(startCol), .lenCode(lenCode), .burstIlv(burstIlv),
    .colOut(colOut), .beatValid(beatValid), .beatLast(beatLast),
    .lenIllegal(lenIllegal)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Beats in a burst; 0 means full page
  function automatic int beatsOf(int code, bit ilv);
    if (code >= 4) return ilv ? 8 : 0;
    return 1 << code;
  endfunction

  function automatic int expCol(int base, int k, int code, bit ilv);
    int bl = beatsOf(code, ilv);
    if (bl == 0) return (base + k) % ROW;
    if (ilv) return (base & ~(bl - 1)) | ((base ^ k) & (bl - 1));
    return (base & ~(bl - 1)) | ((base + k) % bl);
  endfunction

  // Pulse a start; returns at the falling edge where beat 0 is visible
  task automatic beginBurst(int col, int code, bit ilv, bit withStop = 0);
    startCol = COL_W'(col); lenCode = 3'(code); burstIlv = ilv;
    burstStart = 1'b1; burstStop = withStop;
    @(negedge clk);
    burstStart = 1'b0; burstStop = 1'b0;
  endtask

  task automatic checkBeats(string tag, int base, int code, bit ilv, int fromK, int n);
    int bl = beatsOf(code, ilv);
    for (int k = fromK; k < fromK + n; k++) begin
      check({tag, " valid"}, beatValid, 1);
      check({tag, " col"}, colOut, expCol(base, k, code, ilv));
      check({tag, " last R6/R7"}, beatLast, (bl != 0 && k == bl - 1) ? 1 : 0);
      check({tag, " illegal R10"}, lenIllegal, (code >= 4 && ilv) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check("R1 valid", beatValid, 0);
    check("R1 last", beatLast, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", beatValid, 0);
    check("R1 illegal", lenIllegal, 0);
  endtask

  task automatic testSeqFixed(int col, int code);
    beginBurst(col, code, 0);
    check("R2 first col", colOut, col);
    checkBeats("R3 seq", col, code, 0, 0, 1 << code);
    check("R6 ends", beatValid, 0);
  endtask

  task automatic testIlv(int col, int code);
    beginBurst(col, code, 1);
    checkBeats("R4 ilv", col, code, 1, 0, beatsOf(code, 1));
    check("R6 ilv ends", beatValid, 0);
  endtask

  task automatic testFullPage();
    beginBurst(510, 4, 0);
    checkBeats("R5 full", 510, 4, 0, 0, ROW + 10);
    burstStop = 1'b1;
    @(negedge clk);
    burstStop = 1'b0;
    check("R8 stop full page", beatValid, 0);
  endtask

  task automatic testIllegal();
    beginBurst(3, 7, 1);
    checkBeats("R10 illegal", 3, 7, 1, 0, 8);
    check("R10 ends as eight", beatValid, 0);
    check("R10 flag clears", lenIllegal, 0);
  endtask

  task automatic testStop();
    beginBurst(40, 3, 0);
    checkBeats("R8 pre-stop", 40, 3, 0, 0, 3);
    burstStop = 1'b1;
    @(negedge clk);
    burstStop = 1'b0;
    check("R8 stopped", beatValid, 0);
    @(negedge clk);
    check("R8 stays idle", beatValid, 0);
  endtask

  task automatic testRestart();
    beginBurst(0, 3, 0);
    checkBeats("R9 first", 0, 3, 0, 0, 2);
    beginBurst(100, 1, 0);
    checkBeats("R9 replaced", 100, 1, 0, 0, 2);
    check("R9 ends", beatValid, 0);
    // start and stop together: start wins
    beginBurst(17, 2, 1);
    checkBeats("R8 pre", 17, 2, 1, 0, 1);
    beginBurst(200, 2, 0, 1);
    checkBeats("R8 start wins", 200, 2, 0, 0, 4);
    check("R8 start wins ends", beatValid, 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testSeqFixed(5, 0);
    testSeqFixed(6, 2);
    testSeqFixed(9'h1FD, 3);
    testSeqFixed(9'h0AB, 1);
    testIlv(9'h00B, 3);
    testIlv(2, 2);
    testIlv(9'h155, 1);
    testFullPage();
    testIllegal();
    testStop();
    testRestart();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule